// File: doc/BRIEF.md
# Bus Error Capture and Single-Bit ECC Threshold

This block sits beside a system bus controller. It watches for failed transfers and keeps one status and control register. When a transfer ends in error, it records the transfer type and the transfer code of that transaction. It also records whether the error came from an external slave or from this block itself. The record stays frozen until software clears it, so a later error cannot overwrite the first one.

Correctable single-bit ECC errors are counted in an 8-bit counter, and software may preload that counter. While the counter is below 255, single-bit errors are tolerated and do not stop the bus. Once it holds 255, the counter stays there and every further single-bit error is turned into a transfer-error acknowledge. Parity errors and double-bit ECC errors raise the acknowledge at once. One control bit masks every kind of data error. The acknowledge output is combinational, so it is raised in the same cycle as the error input that causes it.

Register layout, as read: bits [7:0] hold the counter, bit 8 is the data-error mask, bit 12 is the capture-valid flag, bit 13 is the external flag, bits [18:16] hold the captured code and bits [24:20] hold the captured type. All other bits are reserved.

Writes use byte enables. Byte lane 0 loads the counter. Byte lane 1 loads the mask from bit 8, and a 1 written to bit 12 clears the capture-valid and external flags. Lanes 2 and 3 are read-only.

Top module: `busErrTrap`

## Requirements
- R1: A single-bit ECC error with data errors enabled and a count below 255 increments the counter (read bits [7:0]) by one on the next clock edge.
- R2: When the counter already holds 255, every enabled single-bit error raises `teaOut` in the same cycle, and the counter stays at 255.
- R3: A single-bit error seen while the counter is below 255 does not raise `teaOut`.
- R4: While the mask bit (read bit 8) is 1, parity, single-bit and double-bit errors neither raise `teaOut`, change the counter, nor capture a record.
- R5: An enabled parity error or double-bit error raises `teaOut` in the same cycle and leaves the counter unchanged.
- R6: The first error after a clear is recorded: either `teaOut` high or `extTea` high. Recording sets capture-valid (bit 12), stores `xferCode` in bits [18:16] and stores `xferType` in bits [24:20].
- R7: The external flag (bit 13) is set to 1 when the recorded error came from `extTea`, and to 0 when it came only from internal escalation.
- R8: While capture-valid is 1, the captured fields do not change. A byte-lane-1 write with bit 12 set clears capture-valid and the external flag, and this clear takes priority over a capture in the same cycle.
- R9: A byte-lane-0 write loads the counter with `wrData[7:0]`. The write wins over an increment in the same cycle, and escalation in that cycle uses the old count.
- R10: After reset every register field reads 0, and reserved bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrBe | input | 4 | Byte enables of the write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register value |
| sglEccErr | input | 1 | Correctable single-bit ECC error on this transfer |
| dblEccErr | input | 1 | Uncorrectable double-bit ECC error |
| parityErr | input | 1 | Data parity error |
| extTea | input | 1 | Transfer error raised by an external slave |
| xferType | input | 5 | Transfer type of the current transaction |
| xferCode | input | 3 | Transfer code of the current transaction |
| teaOut | output | 1 | Transfer-error acknowledge raised by this block |

## Verification
The bench targets the counter boundary. It preloads values just below 255 and walks each one into saturation. A design with an off-by-one compare would escalate one error early, and one that wraps would fall back to zero.

The bench also applies a counter write and a single-bit error in the same cycle. A design that let the increment win would read one too high.

It sweeps every type and code pair with a clear between captures. It also fires a second error while a record is held, and a clear together with an error, so a design that overwrites or re-captures shows wrong fields. With the mask set, it applies every data-error kind and checks that nothing moves.

// File: rtl/busErrPkg.sv
package busErrPkg;
  localparam int REG_W   = 32;
  localparam int DMD_BIT = 8;
  localparam int VLD_BIT = 12;
  localparam int EXT_BIT = 13;
  localparam int TC_LSB  = 16;
  localparam int TT_LSB  = 20;

  typedef struct packed {
    logic cntLoad;
    logic cntInc;
    logic dmdLoad;
    logic capLoad;
    logic capClear;
  } strobeT;
endpackage

// File: rtl/busErrCtrl.sv
module busErrCtrl
  import busErrPkg::*;
(
  input  logic   wrEn,
  input  logic   beCnt,
  input  logic   beCtl,
  input  logic   clrReq,
  input  logic   dmd,
  input  logic   cntSat,
  input  logic   capValid,
  input  logic   sglEccErr,
  input  logic   dblEccErr,
  input  logic   parityErr,
  input  logic   extTea,
  output strobeT stb,
  output logic   teaOut
);
  logic dataEn;
  logic sglHit;
  logic escalate;
  logic anyErr;

  always_comb begin
    dataEn       = !dmd;
    sglHit       = dataEn && sglEccErr;
    escalate     = sglHit && cntSat;
    teaOut       = escalate || (dataEn && (dblEccErr || parityErr));
    anyErr       = teaOut || extTea;
    stb.cntLoad  = wrEn && beCnt;
    stb.cntInc   = sglHit && !cntSat && !stb.cntLoad;
    stb.dmdLoad  = wrEn && beCtl;
    stb.capClear = wrEn && beCtl && clrReq;
    stb.capLoad  = anyErr && !capValid && !stb.capClear;
  end
endmodule

// File: rtl/busErrDpath.sv
module busErrDpath
  import busErrPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TT_W  = 5,
  parameter int TC_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [CNT_W-1:0] cntWrVal,
  input  logic             dmdWrVal,
  input  logic             extTea,
  input  logic [TT_W-1:0]  xferType,
  input  logic [TC_W-1:0]  xferCode,
  output logic             dmd,
  output logic             cntSat,
  output logic             capValid,
  output logic [REG_W-1:0] rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             extFlag;
  logic [TT_W-1:0]  capType;
  logic [TC_W-1:0]  capCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.cntLoad) begin
      cnt <= cntWrVal;
    end else if (stb.cntInc) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmd <= 1'b0;
    end else if (stb.dmdLoad) begin
      dmd <= dmdWrVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValid <= 1'b0;
      extFlag  <= 1'b0;
      capType  <= '0;
      capCode  <= '0;
    end else if (stb.capClear) begin
      capValid <= 1'b0;
      extFlag  <= 1'b0;
    end else if (stb.capLoad) begin
      capValid <= 1'b1;
      extFlag  <= extTea;
      capType  <= xferType;
      capCode  <= xferCode;
    end
  end

  always_comb begin
    cntSat                   = (cnt == CNT_MAX);
    rdData                   = '0;
    rdData[CNT_W-1:0]        = cnt;
    rdData[DMD_BIT]          = dmd;
    rdData[VLD_BIT]          = capValid;
    rdData[EXT_BIT]          = extFlag;
    rdData[TC_LSB +: TC_W]   = capCode;
    rdData[TT_LSB +: TT_W]   = capType;
  end
endmodule

// File: rtl/busErrTrap.sv
module busErrTrap
  import busErrPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TT_W  = 5,
  parameter int TC_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [3:0]       wrBe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             sglEccErr,
  input  logic             dblEccErr,
  input  logic             parityErr,
  input  logic             extTea,
  input  logic [TT_W-1:0]  xferType,
  input  logic [TC_W-1:0]  xferCode,
  output logic             teaOut
);
  strobeT stb;
  logic   dmd;
  logic   cntSat;
  logic   capValid;

  busErrCtrl ctrl_i (
    .wrEn      (wrEn),
    .beCnt     (wrBe[0]),
    .beCtl     (wrBe[1]),
    .clrReq    (wrData[VLD_BIT]),
    .dmd       (dmd),
    .cntSat    (cntSat),
    .capValid  (capValid),
    .sglEccErr (sglEccErr),
    .dblEccErr (dblEccErr),
    .parityErr (parityErr),
    .extTea    (extTea),
    .stb       (stb),
    .teaOut    (teaOut)
  );

  busErrDpath #(.CNT_W(CNT_W), .TT_W(TT_W), .TC_W(TC_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cntWrVal (wrData[CNT_W-1:0]),
    .dmdWrVal (wrData[DMD_BIT]),
    .extTea   (extTea),
    .xferType (xferType),
    .xferCode (xferCode),
    .dmd      (dmd),
    .cntSat   (cntSat),
    .capValid (capValid),
    .rdData   (rdData)
  );
endmodule

// File: rtl/busErrTrapChk.sv
module busErrTrapChk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  wrBe,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        sglEccErr,
  input logic        dblEccErr,
  input logic        parityErr,
  input logic        teaOut
);
  logic [7:0] cnt;
  logic       dmd;
  logic       vld;
  logic       ldCnt;
  logic       clr;

  assign cnt   = rdData[7:0];
  assign dmd   = rdData[8];
  assign vld   = rdData[12];
  assign ldCnt = wrEn && wrBe[0];
  assign clr   = wrEn && wrBe[1] && wrData[12];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !ldCnt |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 8'd1)); // R1
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == 8'hFF) && !ldCnt |=> cnt == 8'hFF); // R2
  AST_ESCALATE: assert property (@(posedge clk) disable iff (!rstN)
    (!dmd && sglEccErr && cnt == 8'hFF) |-> teaOut); // R2
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    dmd |-> !teaOut); // R4
  AST_HARD_TEA: assert property (@(posedge clk) disable iff (!rstN)
    (!dmd && (dblEccErr || parityErr)) |-> teaOut); // R5
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    vld && !clr |=> $stable(rdData[24:12])); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ldCnt |=> cnt == $past(wrData[7:0])); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & 32'hFE08_CE00) == 32'h0); // R10
endmodule

bind busErrTrap busErrTrapChk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrBe      (wrBe),
  .wrData    (wrData),
  .rdData    (rdData),
  .sglEccErr (sglEccErr),
  .dblEccErr (dblEccErr),
  .parityErr (parityErr),
  .teaOut    (teaOut)
);

// File: tb/busErrTrap_tb.sv
module busErrTrap_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrBe = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sglEccErr = 1'b0;
  logic        dblEccErr = 1'b0;
  logic        parityErr = 1'b0;
  logic        extTea = 1'b0;
  logic [4:0]  xferType = '0;
  logic [2:0]  xferCode = '0;
  logic        teaOut;

  int total = 0;
  int bad = 0;
  logic teaSeen;
  int expCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  busErrTrap dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .wrData(wrData),
    .rdData(rdData), .sglEccErr(sglEccErr), .dblEccErr(dblEccErr),
    .parityErr(parityErr), .extTea(extTea), .xferType(xferType),
    .xferCode(xferCode), .teaOut(teaOut)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One cycle: apply inputs, sample teaOut mid-cycle, pass the edge, settle.
  task automatic cyc(input logic we, input logic [3:0] be, input logic [31:0] d,
                     input logic s, input logic dbl, input logic par, input logic ext,
                     input logic [4:0] tt, input logic [2:0] tc);
    wrEn = we; wrBe = be; wrData = d;
    sglEccErr = s; dblEccErr = dbl; parityErr = par; extTea = ext;
    xferType = tt; xferCode = tc;
    #(CLK_PERIOD/2);
    teaSeen = teaOut;
    @(posedge clk); #1;
    wrEn = 0; wrBe = '0; wrData = '0;
    sglEccErr = 0; dblEccErr = 0; parityErr = 0; extTea = 0;
  endtask

  task automatic clrCap();
    cyc(1, 4'b0010, 32'h0000_1000, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(rdData == 32'h0, "R10 reset value", rdData, 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R1 and R3: count from zero without escalation
    expCnt = 0;
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
      expCnt++;
      chk(teaSeen == 1'b0, "R3 no tea below max", teaSeen, 0);
      chk(rdData[7:0] == expCnt[7:0], "R1 count step", rdData[7:0], expCnt);
    end
    chk(rdData[12] == 1'b0, "R6 no capture on tolerated error", rdData[12], 0);

    // R9 preload then R2 saturation sweep over several start values
    for (int st = 248; st < 256; st++) begin
      cyc(1, 4'b0001, st, 0, 0, 0, 0, 0, 0);
      chk(rdData[7:0] == st[7:0], "R9 preload", rdData[7:0], st);
      expCnt = st;
      for (int k = 0; k < 10; k++) begin
        cyc(0, 0, 0, 1, 0, 0, 0, 5'(k), 3'(k));
        if (expCnt == 255) begin
          chk(teaSeen == 1'b1, "R2 escalation at max", teaSeen, 1);
        end else begin
          chk(teaSeen == 1'b0, "R3 no tea below max", teaSeen, 0);
          expCnt++;
        end
        chk(rdData[7:0] == expCnt[7:0], "R2 saturating count", rdData[7:0], expCnt);
      end
      // R7 internal escalation captured with external flag 0
      chk(rdData[13:12] == 2'b01, "R7 internal record", rdData[13:12], 1);
      clrCap();
      chk(rdData[12] == 1'b0, "R8 clear", rdData[12], 0);
    end

    // R9 write wins over increment; escalation uses old count
    cyc(1, 4'b0001, 32'd17, 1, 0, 0, 0, 0, 0);
    chk(teaSeen == 1'b1, "R9 old count escalates", teaSeen, 1);
    chk(rdData[7:0] == 8'd17, "R9 write wins", rdData[7:0], 17);
    clrCap();
    cyc(1, 4'b0001, 32'd40, 1, 0, 0, 0, 0, 0);
    chk(rdData[7:0] == 8'd40, "R9 write wins below max", rdData[7:0], 40);

    // R4 mask ignores all data errors
    cyc(1, 4'b0010, 32'h0000_0100, 0, 0, 0, 0, 0, 0);
    chk(rdData[8] == 1'b1, "R4 mask set", rdData[8], 1);
    for (int m = 1; m < 8; m++) begin
      cyc(0, 0, 0, m[0], m[1], m[2], 0, 5'd3, 3'd3);
      chk(teaSeen == 1'b0, "R4 masked tea", teaSeen, 0);
      chk(rdData[12:0] == 13'h0128, "R4 masked state", rdData[12:0], 13'h0128);
    end
    cyc(1, 4'b0001, 32'd255, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk(teaSeen == 1'b0, "R4 masked at max", teaSeen, 0);
    cyc(1, 4'b0011, 32'd40, 0, 0, 0, 0, 0, 0);
    chk(rdData[8] == 1'b0, "R4 mask cleared", rdData[8], 0);

    // R5 double-bit and parity errors, counter untouched
    cyc(0, 0, 0, 0, 1, 0, 0, 5'd9, 3'd6);
    chk(teaSeen == 1'b1, "R5 double-bit tea", teaSeen, 1);
    chk(rdData[7:0] == 8'd40, "R5 count untouched", rdData[7:0], 40);
    chk(rdData[24:12] == {5'd9, 1'b0, 3'd6, 2'b00, 2'b01}, "R6 capture fields",
        rdData[24:12], {5'd9, 1'b0, 3'd6, 2'b00, 2'b01});
    // R8 second error does not overwrite
    cyc(0, 0, 0, 0, 0, 1, 1, 5'd30, 3'd1);
    chk(teaSeen == 1'b1, "R5 parity tea", teaSeen, 1);
    chk(rdData[24:12] == {5'd9, 1'b0, 3'd6, 2'b00, 2'b01}, "R8 frozen record",
        rdData[24:12], {5'd9, 1'b0, 3'd6, 2'b00, 2'b01});
    // R8 clear beats capture in the same cycle
    cyc(1, 4'b0010, 32'h0000_1000, 0, 0, 0, 1, 5'd1, 3'd1);
    chk(rdData[13:12] == 2'b00, "R8 clear priority", rdData[13:12], 0);

    // R6 and R7: full sweep of type and code with external errors
    for (int i = 0; i < 256; i++) begin
      cyc(0, 0, 0, 0, 0, 0, 1, 5'(i >> 3), 3'(i));
      chk(teaSeen == 1'b0, "R7 ext not echoed", teaSeen, 0);
      chk(rdData[24:12] == {5'(i >> 3), 1'b0, 3'(i), 2'b00, 2'b11}, "R6 R7 sweep capture",
          rdData[24:12], {5'(i >> 3), 1'b0, 3'(i), 2'b00, 2'b11});
      clrCap();
    end
    chk((rdData & 32'hFE08_CE00) == 0, "R10 reserved zero", rdData, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule